// File: doc/BRIEF.md
# Sixteen-Function Word ALU

This block is the arithmetic and logic unit of a small 16-bit processor. It takes two operand words and a four-bit function selector and produces one 16-bit result word. The function set covers plain bitwise logic, modular add, subtract and multiply, signed comparisons that return a register value of 0 or 1, single-position shifts, a byte-merge that loads a new high byte while keeping the low byte of the first operand, and bit manipulation (set, clear, test and one-hot mask) indexed by the low four bits of the second operand.

The decoder in front of the block selects the operands and the function. The function is evaluated combinationally, and the result is captured in an output register on the next rising clock edge, so each result is ready one cycle after its inputs. No flags or condition codes are produced. A synchronous, active-high reset clears the output register.

Top module: `word_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` is loaded with 0x0000. Otherwise the result for the inputs present at a rising edge appears on `result` right after that edge and stays there until the next edge.
- R2: Selector 0000 returns `op_b` unchanged.
- R3: Selector 0001 returns `op_a & op_b`, 0010 returns `op_a | op_b` and 0011 returns `op_a ^ op_b`.
- R4: Selector 0100 returns `op_a + op_b` and 0101 returns `op_a - op_b`, both modulo 2^16.
- R5: Selector 0110 returns the low 16 bits of the unsigned product `op_a * op_b`.
- R6: Selector 0111 returns `op_b[7:0]` in bits 15:8 and `op_a[7:0]` in bits 7:0.
- R7: Selector 1000 returns 0x0001 when `op_a < op_b` and 1001 returns 0x0001 when `op_a <= op_b`, with both operands taken as signed two's complement; otherwise each returns 0x0000.
- R8: Selector 1010 shifts `op_a` right by one position and puts zero in bit 15. Selector 1011 shifts `op_a` left by one position and puts zero in bit 0.
- R9: With k = `op_b[3:0]`, selector 1100 returns `op_a` with bit k forced to 1 and 1101 returns `op_a` with bit k forced to 0. Bits 15:4 of `op_b` have no effect on the result.
- R10: With k = `op_b[3:0]`, selector 1110 returns `op_a & (1 << k)` and 1111 returns `1 << k`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 16 | First operand word |
| op_b | input | 16 | Second operand word; bits 3:0 are the bit index for selectors 1100 to 1111 |
| fn_sel | input | 4 | Function selector |
| result | output | 16 | Registered result word |

## Verification
Every result is due exactly one rising edge after its operands and selector are applied. A reset also takes effect at that one edge. The bench changes the inputs on a falling edge. It compares `result` with its behavioural model on the next falling edge, half a cycle after the capturing edge and before the next inputs are applied. Because a new operand set goes in every cycle, each compare checks only the result of the single operand set applied one edge before it. The bound checker applies the same one-cycle offset by relating `result` to the `$past` values of the inputs. It does this only after one edge with reset low has passed.

// File: rtl/word_alu_pkg.sv
`timescale 1ns/1ps
package word_alu_pkg;

  localparam int unsigned FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_PASSB = 4'b0000,
    FN_AND   = 4'b0001,
    FN_OR    = 4'b0010,
    FN_XOR   = 4'b0011,
    FN_ADD   = 4'b0100,
    FN_SUB   = 4'b0101,
    FN_MUL   = 4'b0110,
    FN_MERGE = 4'b0111,
    FN_LT    = 4'b1000,
    FN_LE    = 4'b1001,
    FN_SHR   = 4'b1010,
    FN_SHL   = 4'b1011,
    FN_BSET  = 4'b1100,
    FN_BCLR  = 4'b1101,
    FN_BTST  = 4'b1110,
    FN_BMASK = 4'b1111
  } fn_t;

  // Which sub-unit owns a selector value.
  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_BITS  = 2'd2
  } grp_t;

  function automatic grp_t fn_group(fn_t f);
    case (f)
      FN_PASSB, FN_AND, FN_OR, FN_XOR, FN_MERGE: fn_group = GRP_LOGIC;
      FN_ADD, FN_SUB, FN_MUL, FN_LT, FN_LE:      fn_group = GRP_ARITH;
      default:                                   fn_group = GRP_BITS;
    endcase
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit
  import word_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fn_t          fn,
  output logic [W-1:0] res
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] merged;

  // The upper half comes from the low half of b. The lower half is kept from a.
  assign merged = {b[HALF-1:0], a[HALF-1:0]};

  always_comb begin
    case (fn)
      FN_PASSB: res = b;
      FN_AND:   res = a & b;
      FN_OR:    res = a | b;
      FN_XOR:   res = a ^ b;
      FN_MERGE: res = merged;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit
  import word_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fn_t          fn,
  output logic [W-1:0] res
);

  logic         do_sub;
  logic [W-1:0] b_in;
  logic [W-1:0] sum;
  logic [W-1:0] prod;
  logic         ovf;
  logic         is_lt;
  logic         is_eq;

  // One adder is shared by add, subtract and both compares.
  assign do_sub = (fn == FN_SUB) || (fn == FN_LT) || (fn == FN_LE);
  assign b_in   = do_sub ? ~b : b;
  assign sum    = a + b_in + {{(W-1){1'b0}}, do_sub};

  // Signed overflow of a - b: the operand signs differ and the difference sign differs from a.
  assign ovf   = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
  assign is_lt = sum[W-1] ^ ovf;
  assign is_eq = (sum == '0);

  // Keep only the low word of the product.
  assign prod = a * b;

  always_comb begin
    case (fn)
      FN_ADD:  res = sum;
      FN_SUB:  res = sum;
      FN_MUL:  res = prod;
      FN_LT:   res = {{(W-1){1'b0}}, is_lt};
      FN_LE:   res = {{(W-1){1'b0}}, is_lt | is_eq};
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_bit_unit.sv
`timescale 1ns/1ps
module alu_bit_unit
  import word_alu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     a,
  input  logic [IDX_W-1:0] idx,
  input  fn_t              fn,
  output logic [W-1:0]     res
);

  logic [W-1:0] onehot;

  // Decoder from bit index to a one-hot mask, one comparator per bit.
  for (genvar i = 0; i < W; i++) begin : g_dec
    assign onehot[i] = (idx == IDX_W'(i));
  end

  always_comb begin
    case (fn)
      FN_SHR:   res = {1'b0, a[W-1:1]};
      FN_SHL:   res = {a[W-2:0], 1'b0};
      FN_BSET:  res = a | onehot;
      FN_BCLR:  res = a & ~onehot;
      FN_BTST:  res = a & onehot;
      FN_BMASK: res = onehot;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/word_alu.sv
`timescale 1ns/1ps
module word_alu
  import word_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [W-1:0]               op_a,
  input  logic [W-1:0]               op_b,
  input  logic [word_alu_pkg::FN_W-1:0] fn_sel,
  output logic [W-1:0]               result
);

  localparam int unsigned IDX_W = $clog2(W);

  fn_t          fn;
  logic [W-1:0] r_logic;
  logic [W-1:0] r_arith;
  logic [W-1:0] r_bits;
  logic [W-1:0] r_next;

  assign fn = fn_t'(fn_sel);

  alu_logic_unit #(.W(W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .fn  (fn),
    .res (r_logic)
  );

  alu_arith_unit #(.W(W)) u_arith (
    .a   (op_a),
    .b   (op_b),
    .fn  (fn),
    .res (r_arith)
  );

  alu_bit_unit #(.W(W), .IDX_W(IDX_W)) u_bits (
    .a   (op_a),
    .idx (op_b[IDX_W-1:0]),
    .fn  (fn),
    .res (r_bits)
  );

  always_comb begin
    case (fn_group(fn))
      GRP_LOGIC: r_next = r_logic;
      GRP_ARITH: r_next = r_arith;
      default:   r_next = r_bits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= r_next;
  end

endmodule

// File: rtl/word_alu_checker.sv
`timescale 1ns/1ps
module word_alu_checker
  import word_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         op_a,
  input logic [W-1:0]         op_b,
  input logic [FN_W-1:0]      fn_sel,
  input logic [W-1:0]         result
);

  localparam int unsigned IDX_W = $clog2(W);

  logic armed;
  logic live;

  // live: the previous edge saw reset low after a reset, so result holds a function result.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      live  <= 1'b0;
    end else begin
      live  <= armed;
    end
  end

  // R2: pass-through of b
  assert_passb_R2: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn_sel) == FN_PASSB) |-> (result == $past(op_b)));

  // R7: compares produce only 0 or 1
  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(fn_sel) == FN_LT || $past(fn_sel) == FN_LE))
      |-> (result[W-1:1] == '0));

  // R8: right shift fills the top bit with zero
  assert_shr_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn_sel) == FN_SHR) |-> (result[W-1] == 1'b0));

  // R9: the indexed bit is set by bit-set and cleared by bit-clear
  assert_bset_R9: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn_sel) == FN_BSET) |-> (result[$past(op_b[IDX_W-1:0])] == 1'b1));

  assert_bclr_R9: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn_sel) == FN_BCLR) |-> (result[$past(op_b[IDX_W-1:0])] == 1'b0));

  // R10: the mask function yields exactly one set bit
  assert_mask_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fn_sel) == FN_BMASK) |-> ($countones(result) == 1));

endmodule

bind word_alu word_alu_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .fn_sel (fn_sel),
  .result (result)
);

// File: tb/sim_word_alu.sv
`timescale 1ns/1ps
module sim_word_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [3:0]  fn_sel = '0;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  word_alu u0 (
    .clk    (clk),
    .rst    (rst),
    .op_a   (op_a),
    .op_b   (op_b),
    .fn_sel (fn_sel),
    .result (result)
  );

  // Behavioural reference written with integer arithmetic.
  function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic [3:0] f);
    longint ua = a;
    longint ub = b;
    int     sa = $signed(a);
    int     sb = $signed(b);
    int     k  = b % 16;
    longint bit_k = longint'(1) << k;
    longint r;
    case (f)
      4'd0:  r = ub;
      4'd1:  r = ua & ub;
      4'd2:  r = ua | ub;
      4'd3:  r = ua ^ ub;
      4'd4:  r = ua + ub;
      4'd5:  r = ua - ub + 65536;
      4'd6:  r = ua * ub;
      4'd7:  r = (ub % 256) * 256 + (ua % 256);
      4'd8:  r = (sa < sb) ? 1 : 0;
      4'd9:  r = (sa <= sb) ? 1 : 0;
      4'd10: r = ua / 2;
      4'd11: r = ua * 2;
      4'd12: r = ua | bit_k;
      4'd13: r = ((ua / bit_k) % 2 == 1) ? ua - bit_k : ua;
      4'd14: r = ((ua / bit_k) % 2 == 1) ? bit_k : 0;
      default: r = bit_k;
    endcase
    return 16'(r % 65536);
  endfunction

  function automatic string tag(logic [3:0] f);
    case (f)
      4'd0:                  return "R2";
      4'd1, 4'd2, 4'd3:      return "R3";
      4'd4, 4'd5:            return "R4";
      4'd6:                  return "R5";
      4'd7:                  return "R6";
      4'd8, 4'd9:            return "R7";
      4'd10, 4'd11:          return "R8";
      4'd12, 4'd13:          return "R9";
      default:               return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Inputs change on a falling edge. The result is sampled one falling edge later.
  task automatic run(logic [15:0] a, logic [15:0] b, logic [3:0] f);
    op_a = a; op_b = b; fn_sel = f;
    @(negedge clk);
    check(tag(f), result, model(a, b, f),
          $sformatf("fn=%b a=%h b=%h", f, a, b));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] edges [4];
    edges[0] = 16'h0000; edges[1] = 16'h7FFF;
    edges[2] = 16'h8000; edges[3] = 16'hFFFF;

    // R1: reset state
    op_a = 16'h1234; op_b = 16'h5678; fn_sel = 4'd4;
    repeat (2) @(negedge clk);
    check("R1", result, 16'h0000, "result under reset");
    rst = 1'b0;

    // R1: result arrives one edge after the inputs
    run(16'h0003, 16'h0004, 4'd4);

    // every function with edge operand pairs
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run(edges[i], edges[j], 4'(f));

    // every function with random operands
    for (int f = 0; f < 16; f++)
      for (int n = 0; n < 40; n++)
        run(16'($urandom), 16'($urandom), 4'(f));

    // R7: signed boundaries and the equality case
    run(16'h8000, 16'h7FFF, 4'd8);   // most negative < most positive
    run(16'h7FFF, 16'h8000, 4'd8);
    run(16'h1234, 16'h1234, 4'd8);   // equal: not less
    run(16'h1234, 16'h1234, 4'd9);   // equal: less or equal

    // R6: byte merge with distinct halves
    run(16'hABCD, 16'h1234, 4'd7);   // expect 0x34CD

    // R8: the bits shifted out are dropped
    run(16'h8001, 16'h0000, 4'd10);
    run(16'h8001, 16'h0000, 4'd11);

    // R9, R10: upper bits of op_b are ignored and bit 15 is reachable
    run(16'h0000, 16'hFFF3, 4'd12);
    run(16'hFFFF, 16'hABCF, 4'd13);
    run(16'h8000, 16'h5A5F, 4'd14);
    run(16'h0000, 16'hFFF0, 4'd15);

    // R1: a reset in the middle of operation clears a nonzero result
    run(16'h00FF, 16'h0001, 4'd2);
    op_a = 16'hFFFF; op_b = 16'h0001; fn_sel = 4'd4;
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, 16'h0000, "mid-run reset");
    rst = 1'b0;
    run(16'h0010, 16'h0020, 4'd4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule